// File: doc/BRIEF.md
# I2C Interrupt Status Flag Register

This block keeps the interrupt and status flags of an I2C controller and the interrupt-vector logic that goes with them. The controller core sends one-cycle event pulses into it: arbitration lost, missing acknowledge, byte end, data-count expiry, receive load, receive shift full, transmit load, START and STOP conditions, own-address match, general call, address mismatch, transmit underflow, NACK sent and target-transmitter direction. Strobes from the neighbouring data and command registers also come in: transmit-data write, receive-data read, and start and stop command.

Each flag is set and cleared by its own rules. Software sees the flags through a small register bus that has three addresses: a status word, an enable mask for the six interrupting flags, and a vector register. The vector register returns the code of the lowest-numbered enabled pending flag. Reading it clears that flag when the flag is arbitration lost, no-acknowledge or stop detected.

The interrupt output is the OR of the enabled pending flags. A one-cycle abort pulse tells the command logic to drop its master, start and stop bits after arbitration is lost.

Top module: `i2c_irq_flags`

## Requirements
- R1: After reset the status word, the mask, the vector code and irq all read 0. This includes the transmit-shift-not-empty flag (bit 10).
- R2: The status word (address 0) places its flags at these bits: arbitration lost 0, no-acknowledge 1, access ready 2, receive ready 3, transmit ready 4, stop detected 5, general call 8, addressed as target 9, transmit-shift-not-empty 10, overrun 11, bus busy 12, NACK sent 13, target direction 14. Bits 7:6 and 31:15 read 0.
- R3: Writing 1 to status bits 0, 1, 2, 3, 5, 13 or 14 clears that flag. Writing to bits 8 to 12 or to reserved bits has no effect.
- R4: Transmit ready (bit 4) is set by a transmit load or by a CPU write of 1 to bit 4. A transmit-data write clears it.
- R5: Receive ready is set by a receive load. Overrun is set by a receive-shift-full event while receive ready is still 1, and by every receive load while repeat mode is on. A receive-data read clears both.
- R6: Transmit-shift-not-empty goes to 0 on underflow and to 1 on a transmit-data write. It is also forced to 1 by a start or stop command when repeat mode and master-transmit are on and the flag is 0.
- R7: Access ready is set on byte end when repeat mode is on. When repeat mode is off, it is set when the data count expires and no stop command is pending. It is cleared by a transmit-data write, a receive-data read, or a start or stop command.
- R8: START sets bus busy and clears general call and target direction. STOP clears bus busy, general call, addressed as target and target direction, and sets stop detected. General call sets both general call and addressed as target. Own-address match sets addressed as target. An address mismatch clears addressed as target. Target-transmit sets target direction. NACK-sent sets bit 13.
- R9: The vector register (address 2) reads i+1 for the lowest bit i in 0..5 that is both pending and enabled in the mask (address 1, bits 5:0). It reads 0 when no such bit exists.
- R10: Reading the vector register clears the reported flag for codes 1, 2 and 6 only. Codes 3, 4 and 5 leave their flags unchanged.
- R11: irq is high exactly when some flag in bits 5:0 is pending and enabled in the mask. The mask reads back its written value.
- R12: When a hardware set and any clear of the same flag fall in one cycle, the flag ends up set.
- R13: An arbitration-lost event makes abortCmds high for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | AddrW | Register address: 0 status, 1 mask, 2 vector |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe (needed for the vector read side effect) |
| busWrData | input | DataW | Write data |
| busRdData | output | DataW | Read data for busAddr, combinational |
| txDataWr | input | 1 | CPU wrote the transmit data register |
| rxDataRd | input | 1 | CPU read the receive data register |
| cmdStart | input | 1 | Start command issued |
| cmdStop | input | 1 | Stop command issued |
| rptMode | input | 1 | Repeat mode is on |
| masterTx | input | 1 | Controller is master transmitter |
| stpPending | input | 1 | Stop command bit currently set |
| evArbLost | input | 1 | Arbitration lost |
| evNoAck | input | 1 | No acknowledge received |
| evByteEnd | input | 1 | Byte finished |
| evCountZero | input | 1 | Data count passed zero |
| evRxLoad | input | 1 | Receive shift moved into receive data |
| evRxFull | input | 1 | Receive shift full again |
| evTxLoad | input | 1 | Transmit data moved into shift register |
| evStartCond | input | 1 | START seen on the bus |
| evStopCond | input | 1 | STOP sent or seen |
| evOwnAddr | input | 1 | Own address matched |
| evGenCall | input | 1 | All-zero address seen |
| evAddrMiss | input | 1 | Address byte did not match |
| evUnderflow | input | 1 | Transmit underflow |
| evNackSent | input | 1 | A NACK was sent |
| evTgtXmit | input | 1 | Target is transmitting |
| irq | output | 1 | Interrupt request |
| abortCmds | output | 1 | Clear master, start and stop command bits |

## Verification
The bench builds the block with its default parameters: a 32-bit data word, a 2-bit address, and status, mask and vector at addresses 0, 1 and 2. With these values the reserved bits 31:15 of the status word can be read, and an all-ones write reaches every reserved bit and every hardware-only bit. A behavioural model follows every event and strobe, so collisions can be checked in any cycle. These include a vector read racing a new arbitration-lost event and a write-1 clear racing a hardware set.

// File: rtl/i2c_irq_flags_pkg.sv
package i2c_irq_flags_pkg;

  localparam int NUM_VEC  = 6;
  localparam int FLAG_TOP = 14;
  localparam int VEC_W    = $clog2(NUM_VEC + 1);

  localparam int B_ARB    = 0;
  localparam int B_NOACK  = 1;
  localparam int B_ACCRDY = 2;
  localparam int B_RXRDY  = 3;
  localparam int B_TXRDY  = 4;
  localparam int B_STOP   = 5;
  localparam int B_GCALL  = 8;
  localparam int B_ADDRD  = 9;
  localparam int B_TXFULL = 10;
  localparam int B_OVRUN  = 11;
  localparam int B_BUSY   = 12;
  localparam int B_NSENT  = 13;
  localparam int B_TDIR   = 14;

  // flags a CPU write of 1 clears
  localparam logic [FLAG_TOP:0] W1C_MASK  = 15'h602F;
  // flags that hold state (bits 7:6 are reserved)
  localparam logic [FLAG_TOP:0] IMPL_MASK = 15'h7F3F;
  // vector codes whose read clears the flag
  localparam logic [NUM_VEC-1:0] VEC_CLR_MASK = 6'b100011;

  typedef enum logic [1:0] {SEL_STATUS, SEL_MASK, SEL_VECTOR, SEL_NONE} rdSel_e;

  typedef struct packed {
    logic               statusWr;
    logic               maskWr;
    logic [NUM_VEC-1:0] vecClr;
    rdSel_e             rdSel;
    logic [VEC_W-1:0]   vecCode;
  } ctrlStrb_t;

endpackage

// File: rtl/i2c_irq_flags_ctrl.sv
module i2c_irq_flags_ctrl
  import i2c_irq_flags_pkg::*;
#(
  parameter int AddrW      = 2,
  parameter int StatusAddr = 0,
  parameter int MaskAddr   = 1,
  parameter int VectorAddr = 2
) (
  input  logic [AddrW-1:0]   busAddr,
  input  logic               busWrEn,
  input  logic               busRdEn,
  input  logic [NUM_VEC-1:0] pendEn,
  output ctrlStrb_t          strb
);

  logic             hitStatus;
  logic             hitMask;
  logic             hitVector;
  logic [VEC_W-1:0] code;

  assign hitStatus = (busAddr == AddrW'(StatusAddr));
  assign hitMask   = (busAddr == AddrW'(MaskAddr));
  assign hitVector = (busAddr == AddrW'(VectorAddr));

  // lowest enabled pending flag wins
  always_comb begin
    code = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (pendEn[i]) code = VEC_W'(i + 1);
    end
  end

  always_comb begin
    strb.statusWr = busWrEn && hitStatus;
    strb.maskWr   = busWrEn && hitMask;
    strb.vecCode  = code;
    if (hitStatus)      strb.rdSel = SEL_STATUS;
    else if (hitMask)   strb.rdSel = SEL_MASK;
    else if (hitVector) strb.rdSel = SEL_VECTOR;
    else                strb.rdSel = SEL_NONE;
  end

  generate
    for (genvar i = 0; i < NUM_VEC; i++) begin : g_vclr
      if (VEC_CLR_MASK[i]) begin : g_on
        assign strb.vecClr[i] = busRdEn && hitVector && (code == VEC_W'(i + 1));
      end else begin : g_off
        assign strb.vecClr[i] = 1'b0;
      end
    end
  endgenerate

endmodule

// File: rtl/i2c_irq_flags_dp.sv
module i2c_irq_flags_dp
  import i2c_irq_flags_pkg::*;
#(
  parameter int DataW = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrb_t          strb,
  input  logic [DataW-1:0]   busWrData,
  output logic [DataW-1:0]   busRdData,
  input  logic               txDataWr,
  input  logic               rxDataRd,
  input  logic               cmdStart,
  input  logic               cmdStop,
  input  logic               rptMode,
  input  logic               masterTx,
  input  logic               stpPending,
  input  logic               evArbLost,
  input  logic               evNoAck,
  input  logic               evByteEnd,
  input  logic               evCountZero,
  input  logic               evRxLoad,
  input  logic               evRxFull,
  input  logic               evTxLoad,
  input  logic               evStartCond,
  input  logic               evStopCond,
  input  logic               evOwnAddr,
  input  logic               evGenCall,
  input  logic               evAddrMiss,
  input  logic               evUnderflow,
  input  logic               evNackSent,
  input  logic               evTgtXmit,
  output logic [NUM_VEC-1:0] pendEn,
  output logic               irq,
  output logic               abortCmds
);

  localparam int FillW = DataW - FLAG_TOP - 1;

  logic [FLAG_TOP:0]  flagQ;
  logic [FLAG_TOP:0]  flagD;
  logic [FLAG_TOP:0]  setV;
  logic [FLAG_TOP:0]  clrV;
  logic [NUM_VEC-1:0] maskQ;
  logic               unusedWrHigh;

  assign unusedWrHigh = ^busWrData[DataW-1:FLAG_TOP+1];

  always_comb begin
    clrV = '0;
    if (strb.statusWr) clrV = busWrData[FLAG_TOP:0] & W1C_MASK;
    clrV[NUM_VEC-1:0] = clrV[NUM_VEC-1:0] | strb.vecClr;
    if (txDataWr || rxDataRd || cmdStart || cmdStop) clrV[B_ACCRDY] = 1'b1;
    if (txDataWr)    clrV[B_TXRDY] = 1'b1;
    if (rxDataRd)  begin clrV[B_RXRDY] = 1'b1; clrV[B_OVRUN] = 1'b1; end
    if (evUnderflow) clrV[B_TXFULL] = 1'b1;
    if (evStartCond) begin clrV[B_GCALL] = 1'b1; clrV[B_TDIR] = 1'b1; end
    if (evStopCond) begin
      clrV[B_GCALL] = 1'b1;
      clrV[B_ADDRD] = 1'b1;
      clrV[B_TDIR]  = 1'b1;
      clrV[B_BUSY]  = 1'b1;
    end
    if (evAddrMiss)  clrV[B_ADDRD] = 1'b1;
  end

  always_comb begin
    setV = '0;
    setV[B_ARB]    = evArbLost;
    setV[B_NOACK]  = evNoAck;
    setV[B_ACCRDY] = (rptMode && evByteEnd) || (!rptMode && evCountZero && !stpPending);
    setV[B_RXRDY]  = evRxLoad;
    setV[B_TXRDY]  = evTxLoad || (strb.statusWr && busWrData[B_TXRDY]);
    setV[B_STOP]   = evStopCond;
    setV[B_GCALL]  = evGenCall;
    setV[B_ADDRD]  = evOwnAddr || evGenCall;
    setV[B_TXFULL] = txDataWr
                   || (rptMode && masterTx && !flagQ[B_TXFULL] && (cmdStart || cmdStop));
    setV[B_OVRUN]  = (evRxFull && flagQ[B_RXRDY]) || (rptMode && evRxLoad);
    setV[B_BUSY]   = evStartCond;
    setV[B_NSENT]  = evNackSent;
    setV[B_TDIR]   = evTgtXmit;
  end

  // hardware set has priority over every clear
  assign flagD = (flagQ & ~clrV) | setV;

  generate
    for (genvar b = 0; b <= FLAG_TOP; b++) begin : g_flag
      if (IMPL_MASK[b]) begin : g_reg
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) flagQ[b] <= 1'b0;
          else       flagQ[b] <= flagD[b];
        end
      end else begin : g_rsvd
        assign flagQ[b] = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ     <= '0;
      abortCmds <= 1'b0;
    end else begin
      if (strb.maskWr) maskQ <= busWrData[NUM_VEC-1:0];
      abortCmds <= evArbLost;
    end
  end

  assign pendEn = flagQ[NUM_VEC-1:0] & maskQ;
  assign irq    = |pendEn;

  always_comb begin
    unique case (strb.rdSel)
      SEL_STATUS: busRdData = {{FillW{1'b0}}, flagQ};
      SEL_MASK:   busRdData = DataW'(maskQ);
      SEL_VECTOR: busRdData = DataW'(strb.vecCode);
      default:    busRdData = '0;
    endcase
  end

endmodule

// File: rtl/i2c_irq_flags.sv
module i2c_irq_flags
  import i2c_irq_flags_pkg::*;
#(
  parameter int DataW      = 32,
  parameter int AddrW      = 2,
  parameter int StatusAddr = 0,
  parameter int MaskAddr   = 1,
  parameter int VectorAddr = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [AddrW-1:0] busAddr,
  input  logic             busWrEn,
  input  logic             busRdEn,
  input  logic [DataW-1:0] busWrData,
  output logic [DataW-1:0] busRdData,
  input  logic             txDataWr,
  input  logic             rxDataRd,
  input  logic             cmdStart,
  input  logic             cmdStop,
  input  logic             rptMode,
  input  logic             masterTx,
  input  logic             stpPending,
  input  logic             evArbLost,
  input  logic             evNoAck,
  input  logic             evByteEnd,
  input  logic             evCountZero,
  input  logic             evRxLoad,
  input  logic             evRxFull,
  input  logic             evTxLoad,
  input  logic             evStartCond,
  input  logic             evStopCond,
  input  logic             evOwnAddr,
  input  logic             evGenCall,
  input  logic             evAddrMiss,
  input  logic             evUnderflow,
  input  logic             evNackSent,
  input  logic             evTgtXmit,
  output logic             irq,
  output logic             abortCmds
);

  ctrlStrb_t          strb;
  logic [NUM_VEC-1:0] pendEn;

  i2c_irq_flags_ctrl #(
    .AddrW(AddrW), .StatusAddr(StatusAddr), .MaskAddr(MaskAddr), .VectorAddr(VectorAddr)
  ) u_ctrl (
    .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn), .pendEn(pendEn), .strb(strb)
  );

  i2c_irq_flags_dp #(.DataW(DataW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busWrData(busWrData), .busRdData(busRdData),
    .txDataWr(txDataWr), .rxDataRd(rxDataRd), .cmdStart(cmdStart), .cmdStop(cmdStop),
    .rptMode(rptMode), .masterTx(masterTx), .stpPending(stpPending),
    .evArbLost(evArbLost), .evNoAck(evNoAck), .evByteEnd(evByteEnd),
    .evCountZero(evCountZero), .evRxLoad(evRxLoad), .evRxFull(evRxFull),
    .evTxLoad(evTxLoad), .evStartCond(evStartCond), .evStopCond(evStopCond),
    .evOwnAddr(evOwnAddr), .evGenCall(evGenCall), .evAddrMiss(evAddrMiss),
    .evUnderflow(evUnderflow), .evNackSent(evNackSent), .evTgtXmit(evTgtXmit),
    .pendEn(pendEn), .irq(irq), .abortCmds(abortCmds)
  );

endmodule

// File: rtl/i2c_irq_flags_chk.sv
module i2c_irq_flags_chk #(
  parameter int DataW      = 32,
  parameter int AddrW      = 2,
  parameter int StatusAddr = 0,
  parameter int VectorAddr = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic [AddrW-1:0] busAddr,
  input logic             busRdEn,
  input logic [DataW-1:0] busRdData,
  input logic             txDataWr,
  input logic             rxDataRd,
  input logic             evArbLost,
  input logic             evRxLoad,
  input logic             evRxFull,
  input logic             evStartCond,
  input logic             evStopCond,
  input logic             irq,
  input logic             abortCmds
);

  logic atStatus;
  logic atVector;
  assign atStatus = (busAddr == AddrW'(StatusAddr));
  assign atVector = (busAddr == AddrW'(VectorAddr));

  p_abort_pulse_r13: assert property (@(posedge clk) disable iff (!rstN)
    evArbLost |=> abortCmds);

  p_no_abort_r13: assert property (@(posedge clk) disable iff (!rstN)
    !evArbLost |=> !abortCmds);

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    atStatus |-> (busRdData[7:6] == 2'b00 && busRdData[DataW-1:15] == '0));

  p_vector_range_r9: assert property (@(posedge clk) disable iff (!rstN)
    atVector |-> (busRdData <= DataW'(6)));

  p_vector_irq_r11: assert property (@(posedge clk) disable iff (!rstN)
    (atVector && busRdData != '0) |-> irq);

  p_set_wins_r12: assert property (@(posedge clk) disable iff (!rstN)
    evArbLost ##1 atStatus |-> busRdData[0]);

  p_rx_read_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rxDataRd && !evRxLoad && !evRxFull) ##1 atStatus |-> (!busRdData[3] && !busRdData[11]));

  p_vec_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && atVector && busRdData == DataW'(1) && !evArbLost) ##1 atStatus
      |-> !busRdData[0]);

  p_stop_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    (evStopCond && !evStartCond) ##1 atStatus |-> (!busRdData[12] && busRdData[5]));

  p_tx_write_full_r6: assert property (@(posedge clk) disable iff (!rstN)
    txDataWr ##1 atStatus |-> (busRdData[10] && !busRdData[4]) || !$past(txDataWr) );

endmodule

bind i2c_irq_flags i2c_irq_flags_chk #(
  .DataW(DataW), .AddrW(AddrW), .StatusAddr(StatusAddr), .VectorAddr(VectorAddr)
) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRdEn(busRdEn), .busRdData(busRdData),
  .txDataWr(txDataWr), .rxDataRd(rxDataRd), .evArbLost(evArbLost), .evRxLoad(evRxLoad),
  .evRxFull(evRxFull), .evStartCond(evStartCond), .evStopCond(evStopCond),
  .irq(irq), .abortCmds(abortCmds)
);

// File: tb/i2c_irq_flags_tb.sv
module i2c_irq_flags_tb;

  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0]  busAddr = '0;
  logic        busWrEn = 0, busRdEn = 0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic txDataWr = 0, rxDataRd = 0, cmdStart = 0, cmdStop = 0;
  logic rptMode = 0, masterTx = 0, stpPending = 0;
  logic evArbLost = 0, evNoAck = 0, evByteEnd = 0, evCountZero = 0, evRxLoad = 0;
  logic evRxFull = 0, evTxLoad = 0, evStartCond = 0, evStopCond = 0, evOwnAddr = 0;
  logic evGenCall = 0, evAddrMiss = 0, evUnderflow = 0, evNackSent = 0, evTgtXmit = 0;
  logic irq, abortCmds;

  int total = 0;
  int fails = 0;

  i2c_irq_flags u_dut (.*);

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [31:0] mSt = '0;
  logic [5:0]  mMask = '0;
  logic        mAbort = 0;

  function automatic int mVec();
    for (int i = 0; i < 6; i++) if (mSt[i] && mMask[i]) return i + 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    logic [31:0] n;
    int v;
    if (!rstN) begin
      mSt = '0; mMask = '0; mAbort = 0;
    end else begin
      n = mSt;
      v = mVec();
      if (busWrEn && busAddr == 2'd0)
        foreach (n[b]) if (busWrData[b] && (b inside {0, 1, 2, 3, 5, 13, 14})) n[b] = 0;
      if (busWrEn && busAddr == 2'd1) mMask = busWrData[5:0];
      if (busRdEn && busAddr == 2'd2 && (v == 1 || v == 2 || v == 6)) n[v-1] = 0;
      if (txDataWr) begin n[4] = 0; n[2] = 0; end
      if (rxDataRd) begin n[3] = 0; n[11] = 0; n[2] = 0; end
      if (cmdStart || cmdStop) n[2] = 0;
      if (evUnderflow) n[10] = 0;
      if (evStartCond) begin n[8] = 0; n[14] = 0; end
      if (evStopCond) begin n[8] = 0; n[9] = 0; n[12] = 0; n[14] = 0; end
      if (evAddrMiss) n[9] = 0;
      if (evArbLost) n[0] = 1;
      if (evNoAck) n[1] = 1;
      if ((rptMode && evByteEnd) || (!rptMode && evCountZero && !stpPending)) n[2] = 1;
      if (evRxLoad) n[3] = 1;
      if (evTxLoad || (busWrEn && busAddr == 2'd0 && busWrData[4])) n[4] = 1;
      if (evStopCond) n[5] = 1;
      if (evGenCall) begin n[8] = 1; n[9] = 1; end
      if (evOwnAddr) n[9] = 1;
      if (txDataWr || (rptMode && masterTx && !mSt[10] && (cmdStart || cmdStop))) n[10] = 1;
      if ((evRxFull && mSt[3]) || (rptMode && evRxLoad)) n[11] = 1;
      if (evStartCond) n[12] = 1;
      if (evNackSent) n[13] = 1;
      if (evTgtXmit) n[14] = 1;
      mSt = n;
      mAbort = evArbLost;
    end
    #(CLK_P/4);
    chk("R11 irq vs model", 32'(irq), 32'((mSt[5:0] & mMask) != 0));
    chk("R13 abortCmds vs model", 32'(abortCmds), 32'(mAbort));
    case (busAddr)
      2'd0: chk("R2 status vs model", busRdData, mSt);
      2'd1: chk("R11 mask vs model", busRdData, 32'(mMask));
      2'd2: chk("R9 vector vs model", busRdData, 32'(mVec()));
      default: chk("R2 unmapped reads 0", busRdData, 32'h0);
    endcase
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    busAddr = a; busRdEn = 1;
    #1 chk(tag, busRdData, exp);
    tick();
    busRdEn = 0; busAddr = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    busAddr = a; busWrEn = 1; busWrData = d;
    tick();
    busWrEn = 0; busAddr = 0; busWrData = '0;
  endtask

  initial begin
    #(CLK_P * 20000);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rstN = 1;
    tick();
    // R1 reset state
    rd(0, 32'h0, "R1 status after reset");
    rd(2, 32'h0, "R1 vector after reset");
    chk("R1 irq after reset", 32'(irq), 32'h0);
    rd(1, 32'h0, "R1 mask after reset");
    wr(1, 32'h3F);
    rd(1, 32'h3F, "R11 mask readback");
    // arbitration lost
    evArbLost = 1; tick(); evArbLost = 0;
    chk("R13 abort pulse", 32'(abortCmds), 32'h1);
    chk("R11 irq on pending", 32'(irq), 32'h1);
    rd(0, 32'h1, "R2 arb lost at bit0");
    chk("R13 abort single cycle", 32'(abortCmds), 32'h0);
    rd(2, 32'h1, "R9 vector code 1");
    rd(0, 32'h0, "R10 code 1 read clears");
    // no-ack plus stop
    evNoAck = 1; evStopCond = 1; tick(); evNoAck = 0; evStopCond = 0;
    rd(0, 32'h22, "R8 stop sets bit5");
    rd(2, 32'h2, "R10 vector code 2");
    rd(0, 32'h20, "R10 code 2 read clears");
    rd(2, 32'h6, "R10 vector code 6");
    rd(0, 32'h0, "R10 code 6 read clears");
    // receive
    evRxLoad = 1; tick(); evRxLoad = 0;
    rd(0, 32'h08, "R5 receive ready");
    rd(2, 32'h4, "R9 vector code 4");
    rd(0, 32'h08, "R10 code 4 read keeps flag");
    evRxFull = 1; tick(); evRxFull = 0;
    rd(0, 32'h808, "R5 overrun while unread");
    rxDataRd = 1; tick(); rxDataRd = 0;
    rd(0, 32'h0, "R5 data read clears");
    // transmit
    wr(0, 32'h10);
    rd(0, 32'h10, "R4 write 1 sets tx ready");
    txDataWr = 1; tick(); txDataWr = 0;
    rd(0, 32'h400, "R4 R6 tx write clears ready sets shift-full");
    evUnderflow = 1; tick(); evUnderflow = 0;
    rd(0, 32'h0, "R6 underflow");
    evTxLoad = 1; tick(); evTxLoad = 0;
    rd(0, 32'h10, "R4 tx load sets");
    txDataWr = 1; tick(); txDataWr = 0;
    // start, general call, ignored writes
    evStartCond = 1; tick(); evStartCond = 0;
    rd(0, 32'h1400, "R8 start sets busy");
    evGenCall = 1; tick(); evGenCall = 0;
    rd(0, 32'h1700, "R8 general call");
    wr(0, 32'hFFFF_FFFF);
    rd(0, 32'h1710, "R3 hw-only bits ignore writes");
    txDataWr = 1; tick(); txDataWr = 0;
    evStartCond = 1; tick(); evStartCond = 0;
    rd(0, 32'h1600, "R8 start clears general call");
    evAddrMiss = 1; tick(); evAddrMiss = 0;
    rd(0, 32'h1400, "R8 address miss clears");
    evTgtXmit = 1; tick(); evTgtXmit = 0;
    evNackSent = 1; tick(); evNackSent = 0;
    rd(0, 32'h7400, "R8 direction and nack sent");
    wr(0, 32'h6000);
    rd(0, 32'h1400, "R3 write 1 clears 13 14");
    evTgtXmit = 1; tick(); evTgtXmit = 0;
    evStopCond = 1; tick(); evStopCond = 0;
    rd(0, 32'h0420, "R8 stop clears busy and direction");
    wr(0, 32'h20);
    // access ready
    evCountZero = 1; tick(); evCountZero = 0;
    rd(0, 32'h404, "R7 count zero sets");
    cmdStart = 1; tick(); cmdStart = 0;
    rd(0, 32'h400, "R7 start command clears");
    stpPending = 1; evCountZero = 1; tick(); evCountZero = 0; stpPending = 0;
    rd(0, 32'h400, "R7 stop pending blocks");
    rptMode = 1;
    evByteEnd = 1; tick(); evByteEnd = 0;
    rd(0, 32'h404, "R7 byte end in repeat");
    rxDataRd = 1; tick(); rxDataRd = 0;
    rd(0, 32'h400, "R7 data read clears");
    evRxLoad = 1; tick(); evRxLoad = 0;
    rd(0, 32'hC08, "R5 repeat overrun");
    rxDataRd = 1; tick(); rxDataRd = 0;
    evUnderflow = 1; tick(); evUnderflow = 0;
    rd(0, 32'h0, "R6 underflow again");
    masterTx = 1; cmdStop = 1; tick(); cmdStop = 0; masterTx = 0;
    rptMode = 0;
    rd(0, 32'h400, "R6 forced by stop command");
    // set wins
    busAddr = 0; busWrEn = 1; busWrData = 32'h1; evArbLost = 1;
    tick();
    busWrEn = 0; busWrData = '0; evArbLost = 0;
    rd(0, 32'h401, "R12 set beats write clear");
    busAddr = 2; busRdEn = 1; evArbLost = 1;
    #1 chk("R9 vector before race", busRdData, 32'h1);
    tick();
    busRdEn = 0; busAddr = 0; evArbLost = 0;
    rd(0, 32'h401, "R12 set beats vector clear");
    wr(0, 32'h1);
    // mask
    wr(1, 32'h0);
    evNoAck = 1; tick(); evNoAck = 0;
    chk("R11 masked no irq", 32'(irq), 32'h0);
    rd(2, 32'h0, "R9 masked vector 0");
    rd(0, 32'h402, "R3 status keeps masked flag");
    wr(1, 32'h02);
    chk("R11 enabled irq", 32'(irq), 32'h1);
    evRxLoad = 1; tick(); evRxLoad = 0;
    wr(1, 32'h3F);
    rd(2, 32'h2, "R9 lowest wins");
    rd(2, 32'h4, "R9 next code");
    rxDataRd = 1; tick(); rxDataRd = 0;
    rd(0, 32'h400, "R5 final status");
    repeat (2) tick();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule